// File: doc/BRIEF.md
# Keyboard Matrix Scanner

This block walks a key matrix of up to eight rows by eight columns one row at a time. It watches the active-low column inputs for the row being driven, and it counts a key as pressed only after that key reads closed on two consecutive visits to its row. Each newly accepted key becomes a one-byte code that holds the row, the column and the level of the shift input. The code is placed in an eight-entry queue.

A host reads the queue through a small read port. One select value returns the oldest code and removes it from the queue. The other select value returns a status byte that holds the fill level and two sticky error flags. An interrupt line tells the host that codes are waiting, so the host can either poll the status byte or respond to the interrupt.

A runtime pin chooses the key policy. In two-key lockout a key is accepted only while it is the only key closed in the whole matrix. In N-key rollover every key is accepted independently. A second pin chooses whether the scan outputs give a binary row number or a one-hot row select.

Top module: `kbd_matrix_ctrl`

## Requirements
- R1: The row index starts at 0 after reset and advances by one every PRESCALE clocks, wrapping from ROWS-1 back to 0. With decodeScan low, scanOut[2:0] carries the row index and scanOut[7:3] is zero. With decodeScan high, scanOut is one-hot with bit <row> set (active high).
- R2: A column input reads low when the key at the driven row and that column is closed. A key is accepted only after it reads closed at two consecutive samplings of its row. It is entered once per press, and it can be entered again only after a sampling has seen it open.
- R3: Each key code has the shift input level, sampled at the accepting row step, in bit 7. Bit 6 is 0, bits 5:3 hold the row and bits 2:0 hold the column.
- R4: With rolloverMode high (N-key rollover), every debounced key is entered. When several keys of one row become eligible at the same step, the lowest column is entered and each of the others is entered on a later scan.
- R5: With rolloverMode low (two-key lockout), an eligible key is entered only if it is the sole closed key in the matrix, counting the most recent sampling of every row. A key pressed while another is held is entered once the other is released, provided it is still closed.
- R6: Codes leave the queue in arrival order. A data read (rdEn high, rdSel 0) removes the oldest code, and that code appears on rdData in the cycle after the read.
- R7: The queue holds FIFO_DEPTH (8) codes. A new code that arrives while the queue is full, with no data read in the same cycle, is discarded and sets the overrun flag. A data read and a new code in the same cycle both take effect, so the fill level stays the same.
- R8: A data read while the queue is empty returns the most recently removed code (0 after reset) and sets the underrun flag.
- R9: A status read (rdEn high, rdSel 1) returns {2'b00, overrun, underrun, level[3:0]} and then clears both flags. It removes no code.
- R10: irqReq is high in the cycle after any edge that leaves the queue non-empty. The exception is the cycle that follows a data read, in which irqReq is low.
- R11: After reset the queue is empty, both flags are clear, rdData is 0 and irqReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| retLn | input | 8 | Column sense inputs, low when the key at the driven row is closed |
| shiftIn | input | 1 | Shift level stored with each code |
| rolloverMode | input | 1 | 1 selects N-key rollover, 0 selects two-key lockout |
| decodeScan | input | 1 | 1 selects one-hot row outputs, 0 selects a binary row number |
| rdEn | input | 1 | Host read strobe |
| rdSel | input | 1 | 0 selects the data read, 1 selects the status read |
| scanOut | output | 8 | Row drive, binary or one-hot |
| rdData | output | 8 | Registered read result |
| irqReq | output | 1 | Codes-waiting interrupt |

## Verification
Two events can land on the same clock edge: the scanner entering a key code and the host removing a code with a data read. The interesting case is a full queue. The bench fills the queue while more keys in one row are still waiting to be entered. It uses its own model of the scan phase to place a data read exactly on the edge where that row is sampled. It then expects a status byte showing a full queue with no overrun. A cycle-by-cycle queue model also follows every other collision, including overrun drops and reads of an empty queue.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int CODE_W = 8;

  typedef enum logic {
    POLICY_LOCKOUT  = 1'b0,
    POLICY_ROLLOVER = 1'b1
  } keyPolicy_e;

  typedef struct packed {
    logic              push;
    logic [CODE_W-1:0] code;
  } keyStrobe_t;
endpackage

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int PRESCALE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] retLn,
  input  logic       shiftIn,
  input  logic       rolloverMode,
  input  logic       decodeScan,
  output logic [7:0] scanOut,
  output keyStrobe_t keyStb
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [2:0] LAST_ROW = 3'(ROWS - 1);
  localparam logic [7:0] COL_MASK = 8'((1 << COLS) - 1);

  logic [PRE_W-1:0] preCnt;
  logic [2:0]       rowIdx;
  logic             scanTick;
  logic [7:0][7:0]  prevMap, heldMap, nextMap;
  logic [7:0]       rowClosed, candMask, pickMask;
  logic [2:0]       pickCol;
  logic             anyCand, soleKey, allowEntry;
  keyPolicy_e       policy;

  assign policy   = keyPolicy_e'(rolloverMode);
  assign scanTick = (preCnt == PRE_LAST);

  // Row currently driven: closed keys read low
  assign rowClosed = ~retLn & COL_MASK;
  assign candMask  = rowClosed & prevMap[rowIdx] & ~heldMap[rowIdx];

  always_comb begin
    pickCol = '0;
    anyCand = 1'b0;
    for (int c = 7; c >= 0; c--) begin
      if (candMask[c]) begin
        pickCol = 3'(c);
        anyCand = 1'b1;
      end
    end
  end

  always_comb begin
    nextMap         = prevMap;
    nextMap[rowIdx] = rowClosed;
  end

  assign soleKey    = ($countones(nextMap) == 1);
  assign allowEntry = anyCand && ((policy == POLICY_ROLLOVER) || soleKey);
  assign pickMask   = allowEntry ? (8'b1 << pickCol) : 8'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      rowIdx  <= '0;
      prevMap <= '0;
      heldMap <= '0;
    end else begin
      preCnt <= scanTick ? '0 : preCnt + 1'b1;
      if (scanTick) begin
        rowIdx          <= (rowIdx == LAST_ROW) ? 3'd0 : rowIdx + 3'd1;
        prevMap[rowIdx] <= rowClosed;
        heldMap[rowIdx] <= (heldMap[rowIdx] & rowClosed) | pickMask;
      end
    end
  end

  assign keyStb.push = scanTick && allowEntry;
  assign keyStb.code = {shiftIn, 1'b0, rowIdx, pickCol};

  assign scanOut = decodeScan ? (8'b1 << rowIdx) : {5'b0, rowIdx};
endmodule

// File: rtl/kbd_key_fifo.sv
module kbd_key_fifo
  import kbd_scan_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  keyStrobe_t keyStb,
  input  logic       rdEn,
  input  logic       rdSel,
  output logic [7:0] rdData,
  output logic       irqReq,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifoLevel
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  logic [CODE_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count, countNext;
  logic [7:0]        lastData, statusWord;
  logic              ovfFlag, undFlag;
  logic              dataRd, statusRd, doPop, doPush, ovfSet, undSet;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign dataRd   = rdEn && !rdSel;
  assign statusRd = rdEn && rdSel;
  assign doPop    = dataRd && (count != '0);
  assign doPush   = keyStb.push && ((count != FULL_LVL) || doPop);
  assign ovfSet   = keyStb.push && (count == FULL_LVL) && !doPop;
  assign undSet   = dataRd && (count == '0);
  assign countNext = count + CNT_W'(doPush) - CNT_W'(doPop);
  assign statusWord = {2'b00, ovfFlag, undFlag, 4'(count)};

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= keyStb.code;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      rdData   <= '0;
      lastData <= '0;
      ovfFlag  <= 1'b0;
      undFlag  <= 1'b0;
      irqReq   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= bumpPtr(wrPtr);
      if (doPop)  rdPtr <= bumpPtr(rdPtr);
      count <= countNext;
      if (statusRd) begin
        rdData <= statusWord;
      end else if (doPop) begin
        rdData   <= mem[rdPtr];
        lastData <= mem[rdPtr];
      end else if (undSet) begin
        rdData <= lastData;
      end
      ovfFlag <= (ovfFlag && !statusRd) || ovfSet;
      undFlag <= (undFlag && !statusRd) || undSet;
      irqReq  <= (countNext != '0) && !dataRd;
    end
  end

  assign fifoLevel = count;
endmodule

// File: rtl/kbd_matrix_ctrl.sv
module kbd_matrix_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int COLS       = 8,
  parameter int PRESCALE   = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] retLn,
  input  logic       shiftIn,
  input  logic       rolloverMode,
  input  logic       decodeScan,
  input  logic       rdEn,
  input  logic       rdSel,
  output logic [7:0] scanOut,
  output logic [7:0] rdData,
  output logic       irqReq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  keyStrobe_t       keyStb;
  logic [CNT_W-1:0] fifoLevel;

  kbd_scan_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .PRESCALE(PRESCALE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .retLn(retLn), .shiftIn(shiftIn),
    .rolloverMode(rolloverMode), .decodeScan(decodeScan),
    .scanOut(scanOut), .keyStb(keyStb)
  );

  kbd_key_fifo #(
    .FIFO_DEPTH(FIFO_DEPTH)
  ) fifo_i (
    .clk(clk), .rstN(rstN), .keyStb(keyStb), .rdEn(rdEn), .rdSel(rdSel),
    .rdData(rdData), .irqReq(irqReq), .fifoLevel(fifoLevel)
  );
endmodule

// File: rtl/kbd_matrix_ctrl_chk.sv
module kbd_matrix_ctrl_chk #(
  parameter int ROWS       = 8,
  parameter int FIFO_DEPTH = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       decodeScan,
  input logic       rdEn,
  input logic       rdSel,
  input logic [7:0] scanOut,
  input logic       irqReq,
  input logic       pushReq,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifoCount
);
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= FIFO_DEPTH);

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && (fifoCount == FIFO_DEPTH) && !(rdEn && !rdSel)) |=> $stable(fifoCount));

  assert_status_nopop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel && !pushReq) |=> $stable(fifoCount));

  assert_irq_after_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdSel) |=> !irqReq);

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && !rdSel) |=> (irqReq == (fifoCount != 0)));

  assert_decoded_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    decodeScan |-> ($countones(scanOut) == 1));

  assert_encoded_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    !decodeScan |-> (scanOut < ROWS));
endmodule

bind kbd_matrix_ctrl kbd_matrix_ctrl_chk #(
  .ROWS(ROWS), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (
  .clk(clk), .rstN(rstN), .decodeScan(decodeScan), .rdEn(rdEn), .rdSel(rdSel),
  .scanOut(scanOut), .irqReq(irqReq), .pushReq(keyStb.push), .fifoCount(fifoLevel)
);

// File: tb/kbd_matrix_ctrl_tb.sv
`timescale 1ns/1ps
module kbd_matrix_ctrl_tb_top;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int PRE  = 4;
  localparam int DEPTH = 8;
  localparam int SCAN = ROWS * PRE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] retLn;
  logic shiftIn = 1'b0, rolloverMode = 1'b1, decodeScan = 1'b0;
  logic rdEn = 1'b0, rdSel = 1'b0;
  logic [7:0] scanOut, rdData;
  logic irqReq;

  logic [63:0] keys = '0;
  int nChecks = 0, nBad = 0;
  bit modelOn = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  kbd_matrix_ctrl #(.ROWS(ROWS), .COLS(COLS), .PRESCALE(PRE), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .retLn(retLn), .shiftIn(shiftIn),
    .rolloverMode(rolloverMode), .decodeScan(decodeScan), .rdEn(rdEn), .rdSel(rdSel),
    .scanOut(scanOut), .rdData(rdData), .irqReq(irqReq)
  );

  // Physical matrix: responds to whatever row the scan lines drive
  int curRow;
  always_comb begin
    curRow = decodeScan ? 0 : int'(scanOut[2:0]);
    if (decodeScan) for (int i = 0; i < 8; i++) if (scanOut[i]) curRow = i;
    for (int c = 0; c < 8; c++) retLn[c] = !keys[curRow*8 + c];
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mPre, mRow, mPick, mTotal;
  logic [63:0] mPrev, mHeld;
  logic [7:0] mQ[$];
  logic [7:0] mRd, mLast, mStat, mCode, mClosed;
  bit mOvr, mUnd, mIrq, mDataRd, mStRd, mPush, mOvSet, mUnSet;

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mRow = 0; mPrev = '0; mHeld = '0; mQ.delete();
      mRd = 0; mLast = 0; mOvr = 0; mUnd = 0; mIrq = 0;
    end else begin
      mDataRd = rdEn && !rdSel;
      mStRd = rdEn && rdSel;
      mStat = {2'b00, mOvr, mUnd, 4'(mQ.size())};
      mPush = 0; mOvSet = 0; mUnSet = 0;
      if (mPre == PRE - 1) begin
        for (int c = 0; c < 8; c++) mClosed[c] = !retLn[c];
        mPick = -1;
        for (int c = 0; c < 8; c++)
          if (mPick < 0 && mClosed[c] && mPrev[mRow*8+c] && !mHeld[mRow*8+c]) mPick = c;
        mTotal = 0;
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < 8; c++)
            mTotal += (r == mRow) ? int'(mClosed[c]) : int'(mPrev[r*8+c]);
        for (int c = 0; c < 8; c++) begin
          mPrev[mRow*8+c] = mClosed[c];
          mHeld[mRow*8+c] = mHeld[mRow*8+c] && mClosed[c];
        end
        if (mPick >= 0 && (rolloverMode || mTotal == 1)) begin
          mHeld[mRow*8+mPick] = 1'b1;
          mPush = 1;
          mCode = {shiftIn, 1'b0, 3'(mRow), 3'(mPick)};
        end
        mRow = (mRow == ROWS - 1) ? 0 : mRow + 1;
        mPre = 0;
      end else mPre++;
      if (mDataRd) begin
        if (mQ.size() > 0) begin mRd = mQ.pop_front(); mLast = mRd; end
        else begin mRd = mLast; mUnSet = 1; end
      end
      if (mStRd) mRd = mStat;
      if (mPush) begin
        if (mQ.size() < DEPTH) mQ.push_back(mCode); else mOvSet = 1;
      end
      if (mStRd) begin mOvr = 0; mUnd = 0; end
      mOvr = mOvr || mOvSet;
      mUnd = mUnd || mUnSet;
      mIrq = (mQ.size() != 0) && !mDataRd;
    end
  end

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check("R1 scanOut", scanOut, decodeScan ? (1 << mRow) : mRow);
      check("R10 irqReq", irqReq, mIrq);
      check("R6 rdData", rdData, mRd);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nBad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic waitScans(int n);
    repeat (n * SCAN) @(negedge clk);
  endtask

  task automatic readData(output logic [7:0] v);
    rdEn = 1; rdSel = 0; @(negedge clk); rdEn = 0; v = rdData;
  endtask

  task automatic readStatus(output logic [7:0] v);
    rdEn = 1; rdSel = 1; @(negedge clk); rdEn = 0; rdSel = 0; v = rdData;
  endtask

  function automatic int kIdx(int r, int c);
    return r * 8 + c;
  endfunction

  logic [7:0] v, prevRd;
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; modelOn = 1;
    @(negedge clk);
    check("R11 irq after reset", irqReq, 0);
    check("R11 rdData after reset", rdData, 0);
    readStatus(v); check("R11 status after reset", v, 8'h00);

    // rollover, shift high, key at row 2 column 5
    shiftIn = 1; keys[kIdx(2,5)] = 1;
    waitScans(3);
    readStatus(v); check("R2 one entry", v, 8'h01);
    check("R10 irq with data", irqReq, 1);
    readData(v); check("R3 code shift/row/col", v, 8'h95);
    check("R10 irq low after read", irqReq, 0);
    waitScans(3);
    readStatus(v); check("R2 no repeat while held", v, 8'h00);
    keys = '0; shiftIn = 0; waitScans(2);

    // rollover, two keys of one row, decoded scan lines
    decodeScan = 1;
    keys[kIdx(0,1)] = 1; keys[kIdx(0,3)] = 1;
    waitScans(4);
    readStatus(v); check("R4 both entered", v, 8'h02);
    readData(v); check("R4 lowest column first", v, 8'h01);
    check("R10 irq low in cycle after read", irqReq, 0);
    @(negedge clk);
    check("R10 irq back with data left", irqReq, 1);
    readData(v); check("R4 second column later", v, 8'h03);
    keys = '0; decodeScan = 0; waitScans(2);

    // two-key lockout
    rolloverMode = 0;
    keys[kIdx(1,1)] = 1; waitScans(3);
    keys[kIdx(4,2)] = 1; waitScans(4);
    readStatus(v); check("R5 second key locked out", v, 8'h01);
    readData(v); check("R5 first key code", v, 8'h09);
    keys[kIdx(1,1)] = 0; waitScans(4);
    readStatus(v); check("R5 entered after release", v, 8'h01);
    readData(v); check("R5 remaining key code", v, 8'h22);
    keys = '0; waitScans(2);

    // overrun: nine keys with no reads
    rolloverMode = 1;
    for (int c = 0; c < 8; c++) keys[kIdx(7,c)] = 1;
    keys[kIdx(6,0)] = 1;
    waitScans(12);
    readStatus(v); check("R7 R9 full with overrun", v, 8'h28);
    readStatus(v); check("R9 flags cleared by status read", v, 8'h08);
    keys = '0; waitScans(2);
    for (int i = 0; i < 8; i++) readData(prevRd);
    readData(v); check("R8 empty read repeats last", v, prevRd);
    readStatus(v); check("R8 underrun flag", v, 8'h10);

    // read and entry on the same edge with a full queue
    for (int c = 0; c < 8; c++) keys[kIdx(3,c)] = 1;
    keys[kIdx(4,0)] = 1; keys[kIdx(4,1)] = 1;
    for (int n = 0; n < 2000; n++) begin
      if (mQ.size() == DEPTH && mPre == PRE - 1 && mRow == 3) break;
      @(negedge clk);
    end
    readData(v);
    readStatus(v); check("R7 push and pop together when full", v, 8'h08);

    keys = '0; waitScans(2);
    for (int i = 0; i < 10; i++) readData(v);
    readStatus(v);
    readStatus(v); check("R9 drained and clear", v, 8'h00);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule